// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It looks at the instruction now in execute and the instruction now in decode. If the execute-stage instruction is a load whose destination register is read by the decode-stage instruction, the block asks for a one-cycle stall. The load result cannot reach the consumer in time, even with bypassing, so the stall is needed.

While the stall is active, the block drops the write enables of the program counter and of the fetch/decode pipeline register, so those two stages keep their contents. In the same cycle it replaces the decoded control word bound for the decode/execute register with all zeros. This sends a no-op bubble into execute. The load and everything older keep moving. One cycle later the load has left execute, the condition clears, and the bypass network (not part of this block) delivers the value.

The logic is purely combinational. A parameter sets the register index width. A second parameter selects whether destination register 0 is treated as a hard-wired zero that never causes a stall.

Top module: `load_use_stall`

## Requirements
- R1: A stall is raised when `ex_is_load` is 1 and `ex_dest_reg` equals `id_src_a`.
- R2: A stall is raised when `ex_is_load` is 1 and `ex_dest_reg` equals `id_src_b`.
- R3: When `ex_is_load` is 0, no stall is raised, whatever the register fields hold.
- R4: When `ex_is_load` is 1 but `ex_dest_reg` matches neither source field, no stall is raised.
- R5: During a stall, `pc_wr_en` and `ifid_wr_en` are both 0. Otherwise both are 1.
- R6: During a stall, `idex_ctrl_out` is all zeros. Otherwise it equals `id_ctrl_in`. The control word layout is: bit 0 register write, bit 1 memory-to-register select, bit 2 memory read (load), bit 3 memory write, bit 4 branch, bit 5 destination select, bit 6 immediate operand select, bits 8:7 ALU operation.
- R7: `bubble_sel` is 1 exactly when a stall is raised, and it is always the inverse of `pc_wr_en`.
- R8: In a pipeline that loads `idex_ctrl_out` into decode/execute each cycle and takes `ex_is_load` from bit 2 of that register, a load followed by a dependent instruction stalls for exactly one cycle. The cycle after the stall has no stall, and the dependent instruction then advances.
- R9: With `SKIP_ZERO_DEST` = 1, a load whose destination is register 0 never stalls. With the default 0, a destination of 0 that matches a source does stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load | input | 1 | Memory-read flag of the instruction in execute |
| ex_dest_reg | input | REG_AW | Destination register of the instruction in execute |
| id_src_a | input | REG_AW | First source register field of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register field of the decode-stage instruction |
| id_ctrl_in | input | 9 | Decoded control word of the decode-stage instruction |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | High when the control word is being replaced with zeros |
| idex_ctrl_out | output | 9 | Control word to load into decode/execute |

## Verification
The freeze of fetch and decode and the zeroing of the execute-bound control word both happen in the stall cycle. The bench therefore checks all four outputs together on every vector, using a nonzero control word so that a missing or partial bubble shows up. A small pipeline model in the bench then runs a load, a dependent add and an unrelated load. It confirms that the hold and the bubble happen in the same single cycle, and that the following cycle passes the dependent instruction on with its real control values.

// File: rtl/lus_pkg.sv
package lus_pkg;

   localparam int CTRL_W = 9;

   typedef struct packed {
      logic [1:0] alu_op;
      logic       alu_src;
      logic       reg_dst;
      logic       branch;
      logic       mem_write;
      logic       mem_read;
      logic       mem_to_reg;
      logic       reg_write;
   } ctrl_word_t;

   localparam ctrl_word_t CTRL_BUBBLE = '0;

endpackage

// File: rtl/lus_reg_match.sv
module lus_reg_match #(
   parameter int REG_AW    = 5,
   parameter bit SKIP_ZERO = 1'b0
) (
   input  logic [REG_AW-1:0] dest,
   input  logic [REG_AW-1:0] src,
   output logic              hit
);

   generate
      if (SKIP_ZERO) begin : g_skip_zero
         assign hit = (dest == src) && (|dest);
      end else begin : g_plain
         assign hit = (dest == src);
      end
   endgenerate

endmodule

// File: rtl/lus_hazard_detect.sv
module lus_hazard_detect #(
   parameter int REG_AW    = 5,
   parameter int NUM_SRC   = 2,
   parameter bit SKIP_ZERO = 1'b0
) (
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] ex_dest,
   input  logic [REG_AW-1:0] id_srcs [NUM_SRC],
   output logic              stall
);

   logic [NUM_SRC-1:0] hits;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         lus_reg_match #(
            .REG_AW    (REG_AW),
            .SKIP_ZERO (SKIP_ZERO)
         ) u_match (
            .dest (ex_dest),
            .src  (id_srcs[i]),
            .hit  (hits[i])
         );
      end
   endgenerate

   assign stall = ex_is_load && (|hits);

   always_comb begin
      if (!ex_is_load) begin
         AST_NO_LOAD_NO_STALL: assert (!stall) else $error("stall without load"); // R3
      end
   end

endmodule

// File: rtl/lus_bubble_mux.sv
module lus_bubble_mux
   import lus_pkg::*;
(
   input  logic       bubble,
   input  ctrl_word_t ctrl_in,
   output ctrl_word_t ctrl_out
);

   assign ctrl_out = bubble ? CTRL_BUBBLE : ctrl_in;

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
   import lus_pkg::*;
#(
   parameter int REG_AW         = 5,
   parameter bit SKIP_ZERO_DEST = 1'b0
) (
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] ex_dest_reg,
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic [CTRL_W-1:0] id_ctrl_in,
   output logic              pc_wr_en,
   output logic              ifid_wr_en,
   output logic              bubble_sel,
   output logic [CTRL_W-1:0] idex_ctrl_out
);

   localparam int NUM_SRC = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if ($bits(ctrl_word_t) != CTRL_W) begin : g_bad_ctrl
         $error("control word width mismatch");
      end
   endgenerate

   logic              stall;
   logic [REG_AW-1:0] srcs [NUM_SRC];
   ctrl_word_t        ctrl_dec;
   ctrl_word_t        ctrl_sel;

   assign srcs[0]  = id_src_a;
   assign srcs[1]  = id_src_b;
   assign ctrl_dec = ctrl_word_t'(id_ctrl_in);

   lus_hazard_detect #(
      .REG_AW    (REG_AW),
      .NUM_SRC   (NUM_SRC),
      .SKIP_ZERO (SKIP_ZERO_DEST)
   ) u_detect (
      .ex_is_load (ex_is_load),
      .ex_dest    (ex_dest_reg),
      .id_srcs    (srcs),
      .stall      (stall)
   );

   lus_bubble_mux u_mux (
      .bubble   (stall),
      .ctrl_in  (ctrl_dec),
      .ctrl_out (ctrl_sel)
   );

   assign pc_wr_en      = ~stall;
   assign ifid_wr_en    = ~stall;
   assign bubble_sel    = stall;
   assign idex_ctrl_out = CTRL_W'(ctrl_sel);

   always_comb begin
      AST_FREEZE_PAIR: assert (pc_wr_en == ifid_wr_en) else $error("enables disagree"); // R5
      AST_SEL_MATCHES_HOLD: assert (bubble_sel == !pc_wr_en) else $error("select vs hold"); // R7
      if (!pc_wr_en) begin
         AST_BUBBLE_ZERO: assert (idex_ctrl_out == '0) else $error("bubble not zero"); // R6
      end else begin
         AST_CTRL_PASS: assert (idex_ctrl_out == id_ctrl_in) else $error("control altered"); // R6
      end
      if (ex_is_load && (ex_dest_reg == id_src_a) && (!SKIP_ZERO_DEST || ex_dest_reg != '0)) begin
         AST_MATCH_A_STALLS: assert (!pc_wr_en) else $error("missed hazard on src a"); // R1
      end
      if (ex_is_load && (ex_dest_reg == id_src_b) && (!SKIP_ZERO_DEST || ex_dest_reg != '0)) begin
         AST_MATCH_B_STALLS: assert (!pc_wr_en) else $error("missed hazard on src b"); // R2
      end
   end

endmodule

// File: tb/load_use_stall_test.sv
module load_use_stall_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 5;
   localparam int CW = 9;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive mux: table mode or pipeline model mode
   logic          pipe_mode = 1'b0;
   logic          tv_load = 1'b0;
   logic [AW-1:0] tv_dest = '0, tv_a = '0, tv_b = '0;
   logic [CW-1:0] tv_ctrl = '0;

   // pipeline model
   localparam logic [CW-1:0] P_CTRL [6] = '{9'h047, 9'h121, 9'h121, 9'h047, 9'h121, 9'h000};
   localparam logic [AW-1:0] P_RS   [6] = '{5'd2, 5'd1, 5'd2, 5'd4, 5'd8, 5'd0};
   localparam logic [AW-1:0] P_RT   [6] = '{5'd1, 5'd5, 5'd3, 5'd7, 5'd9, 5'd0};
   int            pc;
   int            ifid_idx;
   logic          ifid_valid;
   logic [CW-1:0] idex_ctrl;
   logic [AW-1:0] idex_rt;

   logic          ex_is_load;
   logic [AW-1:0] ex_dest_reg, id_src_a, id_src_b;
   logic [CW-1:0] id_ctrl_in;
   logic          pc_wr_en, ifid_wr_en, bubble_sel;
   logic [CW-1:0] idex_ctrl_out;
   logic          pc_wr_en_z, ifid_wr_en_z, bubble_sel_z;
   logic [CW-1:0] idex_ctrl_out_z;

   assign ex_is_load  = pipe_mode ? idex_ctrl[2] : tv_load;
   assign ex_dest_reg = pipe_mode ? idex_rt : tv_dest;
   assign id_src_a    = pipe_mode ? P_RS[ifid_idx] : tv_a;
   assign id_src_b    = pipe_mode ? P_RT[ifid_idx] : tv_b;
   assign id_ctrl_in  = pipe_mode ? (ifid_valid ? P_CTRL[ifid_idx] : '0) : tv_ctrl;

   always_ff @(posedge clk) begin
      if (rst || !pipe_mode) begin
         pc         <= 0;
         ifid_idx   <= 0;
         ifid_valid <= 1'b0;
         idex_ctrl  <= '0;
         idex_rt    <= '0;
      end else begin
         if (pc_wr_en && pc < 5) pc <= pc + 1;
         if (ifid_wr_en) begin
            ifid_idx   <= pc;
            ifid_valid <= 1'b1;
         end
         idex_ctrl <= idex_ctrl_out;
         idex_rt   <= P_RT[ifid_idx];
      end
   end

   load_use_stall #(.REG_AW(AW), .SKIP_ZERO_DEST(1'b0)) uut (
      .ex_is_load(ex_is_load), .ex_dest_reg(ex_dest_reg), .id_src_a(id_src_a),
      .id_src_b(id_src_b), .id_ctrl_in(id_ctrl_in), .pc_wr_en(pc_wr_en),
      .ifid_wr_en(ifid_wr_en), .bubble_sel(bubble_sel), .idex_ctrl_out(idex_ctrl_out)
   );

   load_use_stall #(.REG_AW(AW), .SKIP_ZERO_DEST(1'b1)) uut_z (
      .ex_is_load(ex_is_load), .ex_dest_reg(ex_dest_reg), .id_src_a(id_src_a),
      .id_src_b(id_src_b), .id_ctrl_in(id_ctrl_in), .pc_wr_en(pc_wr_en_z),
      .ifid_wr_en(ifid_wr_en_z), .bubble_sel(bubble_sel_z), .idex_ctrl_out(idex_ctrl_out_z)
   );

   // {load, dest, src_a, src_b, expected stall}
   localparam int NTV = 10;
   localparam logic [16:0] TV [NTV] = '{
      {1'b1, 5'd3,  5'd3,  5'd7,  1'b1},   // R1
      {1'b1, 5'd3,  5'd7,  5'd3,  1'b1},   // R2
      {1'b1, 5'd3,  5'd3,  5'd3,  1'b1},   // R1 and R2 together
      {1'b0, 5'd3,  5'd3,  5'd3,  1'b0},   // R3
      {1'b1, 5'd3,  5'd4,  5'd5,  1'b0},   // R4
      {1'b1, 5'd31, 5'd31, 5'd0,  1'b1},   // R1 top index
      {1'b1, 5'd0,  5'd0,  5'd9,  1'b1},   // R9 default zero stalls
      {1'b0, 5'd0,  5'd0,  5'd0,  1'b0},   // R3
      {1'b1, 5'd16, 5'd0,  5'd16, 1'b1},   // R2
      {1'b1, 5'd1,  5'd2,  5'd4,  1'b0}    // R4 near miss
   };

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int stall_cnt;
      int stall_cyc;
      int pc_at, ifid_at, pc_nx, ifid_nx;
      logic [CW-1:0] ctrl_nx;
      logic stall_nx;
      stall_cyc = -1;
      stall_cnt = 0;
      pc_at = 0; ifid_at = 0; pc_nx = 0; ifid_nx = 0;
      ctrl_nx = '0; stall_nx = 1'b0;

      repeat (2) @(posedge clk);
      @(negedge clk);
      check(pc_wr_en && ifid_wr_en && !bubble_sel && idex_ctrl_out == '0,
            "R5 reset idle", {pc_wr_en, ifid_wr_en, bubble_sel}, 3'b110);

      for (int i = 0; i < NTV; i++) begin
         logic exp;
         logic [CW-1:0] c;
         c = CW'((i * 73) | 9'h109);
         {tv_load, tv_dest, tv_a, tv_b, exp} = TV[i];
         tv_ctrl = c;
         @(negedge clk);
         check(pc_wr_en == !exp, "R1/R2/R3/R4 pc_wr_en", pc_wr_en, !exp);
         check(ifid_wr_en == !exp, "R5 ifid_wr_en", ifid_wr_en, !exp);
         check(bubble_sel == exp, "R7 bubble_sel", bubble_sel, exp);
         check(idex_ctrl_out == (exp ? '0 : c), "R6 control word", idex_ctrl_out, exp ? '0 : c);
      end

      // R9: zero destination with skip option
      tv_load = 1'b1; tv_dest = '0; tv_a = '0; tv_b = 5'd6; tv_ctrl = 9'h1FF;
      @(negedge clk);
      check(pc_wr_en_z && idex_ctrl_out_z == 9'h1FF, "R9 skip zero no stall", pc_wr_en_z, 1);
      check(!pc_wr_en, "R9 default zero stalls", pc_wr_en, 0);
      tv_dest = 5'd6;
      @(negedge clk);
      check(!pc_wr_en_z && idex_ctrl_out_z == '0, "R9 skip variant nonzero stalls", pc_wr_en_z, 0);

      // R6: bubble clears write bits of a full control word
      tv_load = 1'b1; tv_dest = 5'd12; tv_a = 5'd12; tv_b = 5'd1; tv_ctrl = 9'h1FF;
      @(negedge clk);
      check(idex_ctrl_out[0] == 1'b0 && idex_ctrl_out[3] == 1'b0, "R6 write bits cleared",
            idex_ctrl_out, 0);

      // R8: pipeline model run
      tv_load = 1'b0;
      rst = 1'b1;
      pipe_mode = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int cyc = 0; cyc < 12; cyc++) begin
         @(negedge clk);
         if (stall_cyc >= 0 && cyc == stall_cyc + 1) begin
            pc_nx = pc; ifid_nx = ifid_idx; ctrl_nx = idex_ctrl; stall_nx = bubble_sel;
         end
         if (bubble_sel) begin
            stall_cnt++;
            if (stall_cyc < 0) begin
               stall_cyc = cyc; pc_at = pc; ifid_at = ifid_idx;
            end
         end
      end
      check(stall_cnt == 1, "R8 exactly one stall (R4 unused dest no stall)", stall_cnt, 1);
      check(ifid_at == 1, "R8 stall on dependent add", ifid_at, 1);
      check(pc_nx == pc_at && ifid_nx == ifid_at, "R5 pc and ifid held", {pc_nx[7:0], ifid_nx[7:0]},
            {pc_at[7:0], ifid_at[7:0]});
      check(ctrl_nx == '0, "R6 bubble in decode/execute", ctrl_nx, 0);
      check(!stall_nx, "R8 no stall after bubble", stall_nx, 0);
      check(pc == 5, "R8 program advanced", pc, 5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule